// File: doc/BRIEF.md
# Burst Address Sequencer for a Synchronous RAM

This block produces the word address for a four-beat burst into a pipelined synchronous RAM. A new burst begins when either of two active-low address strobes is seen low at a rising clock edge: the processor-side strobe or the controller-side strobe. The external address is then captured into a base register, and the beat counter restarts at zero. After that, each clock edge on which the active-low advance input is low and no strobe is taken moves the burst one beat forward.

Only the two lowest address bits take part in the burst. A static order-select pin chooses how those bits are formed from the captured start value and the beat count. Low selects linear order, a wrapping add. High selects interleaved order, an XOR. The upper address bits stay as captured. The primary chip enable is active low. While it is high, the processor strobe is ignored and a controller strobe deselects the device instead of loading.

Outputs are the full current address and a burst-active flag. The memory array, the data path and the write control are outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: When the processor strobe or the controller strobe is sampled low at a rising edge while chip_en_n is low, the address is captured. From the next cycle, addr_out equals the captured address (beat 0) and burst_active is 1.
- R2: While chip_en_n is high, a low processor strobe is ignored. It causes no load and no deselect, and the edge behaves as if that strobe were high.
- R3: When the controller strobe is sampled low while chip_en_n is high, burst_active goes to 0 from the next cycle. addr_out keeps its value.
- R4: A taken strobe overrides the advance input at the same edge. The load restarts the beat count at 0, even in the middle of a burst.
- R5: At an edge where adv_n is low, burst_active is 1 and no strobe is taken, the beat count goes up by one, modulo 4.
- R6: With order_sel = 0 (linear), the low two bits of addr_out equal (start + beat) mod 4.
- R7: With order_sel = 1 (interleaved), the low two bits of addr_out equal start XOR beat. order_sel is not registered, so addr_out follows it in the same cycle.
- R8: After the fourth beat, a further advance returns the address to the start value. Bits above bit 1 never change except on a load.
- R9: When adv_n is high and no strobe is taken, or when burst_active is 0 and no strobe is taken, addr_out and burst_active hold their values.
- R10: A synchronous active-high reset clears burst_active, the beat count and the captured address. The cycle after reset, addr_out is 0 and burst_active is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External address captured on a load |
| proc_strb_n | input | 1 | Processor address strobe, active low, blocked by chip_en_n high |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| chip_en_n | input | 1 | Primary chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current burst word address |
| burst_active | output | 1 | High while a burst is selected |

## Verification
An error in the beat counter shows in the low two bits of addr_out one cycle after the advance edge that caused it. Such an error then stays visible until the next load, because every later beat is offset from the expected one. A wrong captured base, or a carry that leaks into the upper bits, shows across the whole address in the cycle after a load or wrap. A wrong strobe decision shows at once, in burst_active or in a missing address change one cycle after the edge. Because order_sel acts without a register, flipping it with the counter frozen tells a wrong XOR mapping from a wrong add mapping within the same cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_DESEL = 2'd2,
    CMD_STEP  = 2'd3
  } bseq_cmd_e;

  // Linear order: wrapping add of the start value and the beat count
  function automatic logic [BEAT_W-1:0] beat_linear(input logic [BEAT_W-1:0] start,
                                                    input logic [BEAT_W-1:0] beat);
    return start + beat;
  endfunction

  // Interleaved order: bitwise XOR of the start value and the beat count
  function automatic logic [BEAT_W-1:0] beat_xor(input logic [BEAT_W-1:0] start,
                                                 input logic [BEAT_W-1:0] beat);
    return start ^ beat;
  endfunction

endpackage

// File: rtl/bseq_cmd_dec.sv
module bseq_cmd_dec
  import bseq_pkg::*;
(
  input  logic      proc_strb_n,
  input  logic      ctrl_strb_n,
  input  logic      chip_en_n,
  input  logic      adv_n,
  input  logic      active,
  output bseq_cmd_e cmd,
  output logic      proc_take,
  output logic      ctrl_take,
  output logic      ctrl_desel,
  output logic      step_req
);

  // The processor strobe only counts while the chip is enabled
  assign proc_take  = !proc_strb_n && !chip_en_n;
  assign ctrl_take  = !ctrl_strb_n && !chip_en_n;
  assign ctrl_desel = !ctrl_strb_n &&  chip_en_n;
  assign step_req   = !adv_n && active && ctrl_strb_n && !proc_take;

  always_comb begin
    if (proc_take || ctrl_take) begin
      cmd = CMD_LOAD;
    end else if (ctrl_desel) begin
      cmd = CMD_DESEL;
    end else if (step_req) begin
      cmd = CMD_STEP;
    end else begin
      cmd = CMD_HOLD;
    end
  end

endmodule

// File: rtl/bseq_state.sv
module bseq_state
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  bseq_cmd_e         cmd,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q,
  output logic [BEAT_W-1:0] beat_q,
  output logic              active_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
    end else begin
      case (cmd)
        CMD_LOAD: begin
          base_q   <= addr_in;
          beat_q   <= '0;
          active_q <= 1'b1;
        end
        CMD_DESEL: active_q <= 1'b0;
        CMD_STEP:  beat_q   <= beat_q + 1'b1;
        default: ;
      endcase
    end
  end

  // R1 / R4: a load restarts at beat 0 with the new base
  p_load_restart_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LOAD) |=> (beat_q == '0 && active_q && base_q == $past(addr_in)));

  // R5: a step moves exactly one beat and keeps the base
  p_step_one_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_STEP) |=> (beat_q == $past(beat_q) + 1'b1 && $stable(base_q)));

  // R10: reset clears the flag, the beat and the base
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (beat_q == '0 && !active_q && base_q == '0));

endmodule

// File: rtl/bseq_order.sv
module bseq_order
  import bseq_pkg::*;
(
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  logic              order_sel,
  output logic [BEAT_W-1:0] low_bits
);

  logic [BEAT_W-1:0] lin_bits;
  logic [BEAT_W-1:0] ilv_bits;

  assign lin_bits = beat_linear(start, beat);
  assign ilv_bits = beat_xor(start, beat);
  assign low_bits = order_sel ? ilv_bits : lin_bits;

  // R6 / R7: both orders start at the captured value on beat 0
  always_comb begin
    if (beat == '0) begin
      a_beat0_start_r6: assert (low_bits == start);
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic              chip_en_n,
  input  logic              adv_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_active
);

  localparam int UP_W = ADDR_W - BEAT_W;

  bseq_cmd_e         cmd;
  logic              proc_take;
  logic              ctrl_take;
  logic              ctrl_desel;
  logic              step_req;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic              active_q;
  logic [BEAT_W-1:0] low_bits;
  logic              load_evt;

  bseq_cmd_dec i_dec (
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .chip_en_n   (chip_en_n),
    .adv_n       (adv_n),
    .active      (active_q),
    .cmd         (cmd),
    .proc_take   (proc_take),
    .ctrl_take   (ctrl_take),
    .ctrl_desel  (ctrl_desel),
    .step_req    (step_req)
  );

  bseq_state #(.ADDR_W(ADDR_W)) i_state (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .addr_in  (addr_in),
    .base_q   (base_q),
    .beat_q   (beat_q),
    .active_q (active_q)
  );

  bseq_order i_order (
    .start     (base_q[BEAT_W-1:0]),
    .beat      (beat_q),
    .order_sel (order_sel),
    .low_bits  (low_bits)
  );

  assign load_evt     = proc_take || ctrl_take;
  assign addr_out     = {base_q[ADDR_W-1:BEAT_W], low_bits};
  assign burst_active = active_q;

  // R2: a blocked processor strobe with nothing else pending changes nothing
  p_proc_blocked_r2: assert property (@(posedge clk) disable iff (rst)
    (!proc_strb_n && chip_en_n && ctrl_strb_n && adv_n)
      |=> ($stable(burst_active) && $stable(addr_out[ADDR_W-1:BEAT_W])));

  // R3: controller strobe with the chip disabled drops the flag
  p_desel_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_strb_n && chip_en_n) |=> !burst_active);

  // R8: the upper bits move only on a load
  p_upper_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(addr_out[ADDR_W-1:ADDR_W-UP_W]));

  // R9: no strobe and no advance keeps the address (order pin held)
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (proc_strb_n && ctrl_strb_n && adv_n)
      |=> (!$stable(order_sel) || ($stable(addr_out) && $stable(burst_active))));

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          proc_strb_n = 1'b1;
  logic          ctrl_strb_n = 1'b1;
  logic          chip_en_n = 1'b0;
  logic          adv_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_out;
  logic          burst_active;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_act = 1'b0;
  string         m_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
    .clk(clk), .rst(rst), .addr_in(addr_in), .proc_strb_n(proc_strb_n),
    .ctrl_strb_n(ctrl_strb_n), .chip_en_n(chip_en_n), .adv_n(adv_n),
    .order_sel(order_sel), .addr_out(addr_out), .burst_active(burst_active)
  );

  function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] b,
                                         input logic il);
    int sum;
    if (il) return {s[1] != b[1], s[0] != b[0]};
    sum = int'(s) + int'(b);
    if (sum > 3) sum = sum - 4;
    return sum[1:0];
  endfunction

  function automatic logic [AW-1:0] exp_addr();
    return {m_base[AW-1:2], exp_low(m_base[1:0], m_beat, order_sel)};
  endfunction

  task automatic check(input string tag);
    checks++;
    if (addr_out !== exp_addr() || burst_active !== m_act) begin
      errors++;
      $display("FAIL %s: addr_out=%h active=%b expected addr_out=%h active=%b",
               tag, addr_out, burst_active, exp_addr(), m_act);
    end
  endtask

  // Apply inputs at the falling edge, model the rising edge, check at the next fall
  task automatic cyc(input logic p, input logic c, input logic e, input logic a,
                     input logic [AW-1:0] ad);
    proc_strb_n = p; ctrl_strb_n = c; chip_en_n = e; adv_n = a; addr_in = ad;
    @(posedge clk);
    if (rst) begin
      m_base = '0; m_beat = '0; m_act = 1'b0; m_tag = "R10";
    end else if ((!p && !e) || (!c && !e)) begin
      m_base = ad; m_beat = '0; m_act = 1'b1; m_tag = !a ? "R4" : "R1";
    end else if (!c && e) begin
      m_act = 1'b0; m_tag = "R3";
    end else if (!a && m_act) begin
      m_beat = m_beat + 2'd1; m_tag = (!p) ? "R2" : (order_sel ? "R7" : "R6");
    end else begin
      m_tag = (!p) ? "R2" : "R9";
    end
    @(negedge clk);
    check(m_tag);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    cyc(1, 1, 0, 1, 18'h3ffff);          // R10 reset state
    rst = 1'b0;

    // R1 / R6 / R8: linear burst from start 1, wrap after four beats
    order_sel = 1'b0;
    cyc(0, 1, 0, 1, 18'h2a5f1);
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 18'h0);
    check("R8");

    // R7: interleaved from start 1, then flip order with counter frozen
    order_sel = 1'b1;
    cyc(1, 0, 0, 1, 18'h15555);
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 18'h0);
    order_sel = 1'b0; #1; check("R7");
    order_sel = 1'b1; #1; check("R7");

    // R2: blocked processor strobe, with and without advance
    cyc(0, 1, 1, 1, 18'h00003);
    cyc(0, 1, 1, 0, 18'h00003);

    // R4: controller strobe mid-burst with advance low
    cyc(1, 0, 0, 0, 18'h3fffe);

    // R3: deselect holds the address; R9: no step while inactive
    cyc(1, 0, 1, 0, 18'h00000);
    cyc(1, 1, 0, 0, 18'h00000);

    // R10: reset mid-burst
    cyc(1, 0, 0, 1, 18'h12343);
    rst = 1'b1;
    cyc(1, 1, 0, 0, 18'h0);
    rst = 1'b0;

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic p, c, e, a;
      p = ($urandom_range(0, 7) == 0) ? 1'b0 : 1'b1;
      c = ($urandom_range(0, 7) == 0) ? 1'b0 : 1'b1;
      e = ($urandom_range(0, 3) == 0) ? 1'b1 : 1'b0;
      a = ($urandom_range(0, 3) == 0) ? 1'b1 : 1'b0;
      if (i % 500 == 250) order_sel = ~order_sel;
      cyc(p, c, e, a, AW'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule